// File: doc/BRIEF.md
# UART Receive Status and Interrupt Logic

This block sits between a UART's receive shift register and the CPU. Each time the shift register completes a character it presents the byte together with a framing-error flag and a break flag. The block then places the byte in a single receive data register and keeps a four-bit status word. It also drives one level-sensitive receiver interrupt that combines several sources.

When a character completes while the held byte is still unread, the held byte is protected and the overrun is not shown at first. Only the most recent late character is kept in a hidden staging slot. Reading the protected byte brings the overrun into view: the staged character moves into the data register and must be discarded by software. Software then reads the status and reads the data register again to clear the error bits. A separate baud-rate-generator reload pulse can also raise the interrupt, so the generator can be used as a plain counter.

Status bit positions are fixed: bit 0 data available, bit 1 overrun, bit 2 framing error, bit 3 break.

Top module: `uart_rxq_status`

## Requirements
- R1: A completed character arriving while bit 0 is clear is loaded into the data register one cycle later. Bit 0 sets, and bits 2 and 3 take that character's framing-error and break flags.
- R2: A data read of a character with no overrun clears status bits 0, 2 and 3. The data register keeps its value, because it changes only when a character is loaded.
- R3: A character arriving while bit 0 is set leaves the data register and the status unchanged. Only the last such character is kept in staging, and one overrun is recorded while the overrun is still hidden.
- R4: A data read of the protected byte while an overrun is hidden loads the staged character into the data register. The status then shows bit 0 and bit 1, with bits 2 and 3 taken from the staged character.
- R5: A data read while the overrun is shown but before any status read changes neither the status nor the data register.
- R6: A status read while the overrun is shown, followed by a data read, clears all four status bits.
- R7: When the data-interrupt enable is set, the interrupt is high one cycle after bit 0 is set. When that enable is clear, data available alone never raises it.
- R8: When the error-interrupt enable is set, the interrupt is high one cycle after any of bits 1, 2 or 3 is set. A hidden overrun does not raise it.
- R9: A reload pulse seen while the reload-interrupt enable is set raises the interrupt until the next status read. A pulse seen while that enable is clear is discarded.
- R10: After reset the status, the data register and the interrupt are all zero.
- R11: A data read and a character arriving in the same cycle load the new character as fresh data with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_done | input | 1 | One-cycle pulse: the shift register holds a complete character |
| char_data | input | DW | The completed character |
| char_fe | input | 1 | Framing error on that character |
| char_brk | input | 1 | The character was a line break |
| rd_data_stb | input | 1 | CPU read of the data register |
| rd_stat_stb | input | 1 | CPU read of the status register |
| ie_data | input | 1 | Enable for the received-data interrupt source |
| ie_err | input | 1 | Enable for the overrun, framing and break sources |
| ie_brg | input | 1 | Enable for the reload-pulse source |
| brg_reload | input | 1 | Reload pulse from the baud-rate generator |
| rx_data | output | DW | Receive data register |
| rx_stat | output | 4 | Status: bit 0 available, bit 1 overrun, bit 2 framing, bit 3 break |
| irq | output | 1 | Registered receiver interrupt |

## Verification
The main function is exercised with clean characters, characters carrying framing and break flags, and bursts of two late characters. The bursts show that only the last one is staged and that the overrun appears only after the protected byte is read. A data read inserted before the status read is used to separate the two-read clearing order from a single-read clear. Same-cycle read and arrival separate the read-first ordering from a false overrun. Each interrupt source is toggled alone so that a missing or leaking enable shows up at the interrupt pin.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int STAT_W    = 4;
  localparam int ST_AVAIL  = 0;
  localparam int ST_OVR    = 1;
  localparam int ST_FE     = 2;
  localparam int ST_BRK    = 3;
endpackage

// File: rtl/rxq_hold.sv
module rxq_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          char_done,
  input  logic [DW-1:0] char_data,
  input  logic          char_fe,
  input  logic          char_brk,
  input  logic          rd_data_stb,
  input  logic          rd_stat_stb,
  output logic [DW-1:0] data_q,
  output logic          avail_q,
  output logic          ovr_q,
  output logic          fe_q,
  output logic          brk_q
);
  logic [DW-1:0] stg_d_q, stg_d_n, data_n;
  logic          stg_v_q, stg_v_n, stg_fe_q, stg_fe_n, stg_brk_q, stg_brk_n;
  logic          avail_n, ovr_n, fe_n, brk_n, seen_q, seen_n;

  always_comb begin
    data_n = data_q;  avail_n = avail_q; ovr_n = ovr_q;
    fe_n   = fe_q;    brk_n   = brk_q;   seen_n = seen_q;
    stg_d_n = stg_d_q; stg_v_n = stg_v_q;
    stg_fe_n = stg_fe_q; stg_brk_n = stg_brk_q;

    if (rd_stat_stb && ovr_q) seen_n = 1'b1;

    // read of the data register is applied first
    if (rd_data_stb && avail_q) begin
      if (ovr_q) begin
        if (seen_q) begin
          ovr_n = 1'b0; seen_n = 1'b0;
          if (stg_v_q) begin
            data_n = stg_d_q; avail_n = 1'b1;
            fe_n = stg_fe_q;  brk_n = stg_brk_q; stg_v_n = 1'b0;
          end else begin
            avail_n = 1'b0; fe_n = 1'b0; brk_n = 1'b0;
          end
        end
      end else if (stg_v_q) begin
        data_n = stg_d_q; avail_n = 1'b1; ovr_n = 1'b1;
        fe_n = stg_fe_q;  brk_n = stg_brk_q; stg_v_n = 1'b0;
      end else begin
        avail_n = 1'b0; fe_n = 1'b0; brk_n = 1'b0;
      end
    end

    // then a completed character
    if (char_done) begin
      if (!avail_n) begin
        data_n = char_data; avail_n = 1'b1;
        fe_n = char_fe;     brk_n = char_brk;
      end else begin
        stg_d_n = char_data; stg_v_n = 1'b1;
        stg_fe_n = char_fe;  stg_brk_n = char_brk;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0; avail_q <= 1'b0; ovr_q <= 1'b0; fe_q <= 1'b0;
      brk_q <= 1'b0; seen_q <= 1'b0; stg_d_q <= '0; stg_v_q <= 1'b0;
      stg_fe_q <= 1'b0; stg_brk_q <= 1'b0;
    end else begin
      data_q <= data_n; avail_q <= avail_n; ovr_q <= ovr_n; fe_q <= fe_n;
      brk_q <= brk_n; seen_q <= seen_n; stg_d_q <= stg_d_n; stg_v_q <= stg_v_n;
      stg_fe_q <= stg_fe_n; stg_brk_q <= stg_brk_n;
    end
  end
endmodule

// File: rtl/rxq_brg_src.sv
module rxq_brg_src (
  input  logic clk,
  input  logic rst,
  input  logic brg_reload,
  input  logic ie_brg,
  input  logic rd_stat_stb,
  output logic pend_q
);
  always_ff @(posedge clk) begin
    if (rst)                      pend_q <= 1'b0;
    else if (brg_reload && ie_brg) pend_q <= 1'b1;
    else if (rd_stat_stb)         pend_q <= 1'b0;
  end
endmodule

// File: rtl/rxq_irq_join.sv
module rxq_irq_join (
  input  logic clk,
  input  logic rst,
  input  logic ie_data,
  input  logic ie_err,
  input  logic avail,
  input  logic ovr,
  input  logic fe,
  input  logic brk,
  input  logic brg_pend,
  output logic irq_q
);
  logic data_src, err_src;
  assign data_src = ie_data & avail;
  assign err_src  = ie_err & (ovr | fe | brk);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= data_src | err_src | brg_pend;
  end
endmodule

// File: rtl/uart_rxq_status.sv
module uart_rxq_status #(
  parameter int DW          = 8,
  parameter bit HAS_BRG_SRC = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          char_done,
  input  logic [DW-1:0] char_data,
  input  logic          char_fe,
  input  logic          char_brk,
  input  logic          rd_data_stb,
  input  logic          rd_stat_stb,
  input  logic          ie_data,
  input  logic          ie_err,
  input  logic          ie_brg,
  input  logic          brg_reload,
  output logic [DW-1:0] rx_data,
  output logic [3:0]    rx_stat,
  output logic          irq
);
  import rxq_pkg::*;

  logic avail, ovr, fe, brk, brg_pend;

  rxq_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .char_done(char_done), .char_data(char_data),
    .char_fe(char_fe), .char_brk(char_brk), .rd_data_stb(rd_data_stb),
    .rd_stat_stb(rd_stat_stb), .data_q(rx_data), .avail_q(avail),
    .ovr_q(ovr), .fe_q(fe), .brk_q(brk)
  );

  generate
    if (HAS_BRG_SRC) begin : g_brg
      rxq_brg_src u_brg (
        .clk(clk), .rst(rst), .brg_reload(brg_reload), .ie_brg(ie_brg),
        .rd_stat_stb(rd_stat_stb), .pend_q(brg_pend)
      );
    end else begin : g_nobrg
      assign brg_pend = 1'b0;
    end
  endgenerate

  rxq_irq_join u_irq (
    .clk(clk), .rst(rst), .ie_data(ie_data), .ie_err(ie_err),
    .avail(avail), .ovr(ovr), .fe(fe), .brk(brk),
    .brg_pend(brg_pend), .irq_q(irq)
  );

  always_comb begin
    rx_stat           = '0;
    rx_stat[ST_AVAIL] = avail;
    rx_stat[ST_OVR]   = ovr;
    rx_stat[ST_FE]    = fe;
    rx_stat[ST_BRK]   = brk;
  end
endmodule

// File: rtl/rxq_status_chk.sv
module rxq_status_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          char_done,
  input logic          rd_data_stb,
  input logic          rd_stat_stb,
  input logic          ie_data,
  input logic          ie_err,
  input logic [DW-1:0] rx_data,
  input logic [3:0]    rx_stat,
  input logic          irq
);
  assert_load_when_empty_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(char_done) && !$past(rx_stat[0]) && !$past(rst)) |-> rx_stat[0]);

  assert_data_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(char_done) && !$past(rd_data_stb) && !$past(rst)) |-> $stable(rx_data));

  assert_ovr_shows_on_read_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_stat[1]) |-> $past(rd_data_stb));

  assert_ovr_clears_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_stat[1]) |-> $past(rd_data_stb));

  assert_data_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_stat[0] && ie_data) |=> irq);

  assert_err_irq_R8: assert property (@(posedge clk) disable iff (rst)
    ((rx_stat[1] || rx_stat[2] || rx_stat[3]) && ie_err) |=> irq);

  assert_reset_clear_R10: assert property (@(posedge clk)
    $past(rst) |-> (rx_stat == 4'd0 && !irq && rx_data == '0));
endmodule

bind uart_rxq_status rxq_status_chk #(.DW(DW)) u_chk (.*);

// File: tb/uart_rxq_status_test.sv
module uart_rxq_status_test;
  localparam int DW = 8;
  localparam logic [1:0] OP_CHR = 2'd0, OP_RDD = 2'd1, OP_RDS = 2'd2;
  // {op, data, fe, brk, exp_stat, exp_data}
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {OP_CHR, 8'h41, 1'b0, 1'b0, 4'h1, 8'h41},  // R1
    {OP_RDS, 8'h00, 1'b0, 1'b0, 4'h1, 8'h41},
    {OP_RDD, 8'h00, 1'b0, 1'b0, 4'h0, 8'h41},  // R2
    {OP_CHR, 8'h52, 1'b1, 1'b0, 4'h5, 8'h52},  // R1 framing
    {OP_RDD, 8'h00, 1'b0, 1'b0, 4'h0, 8'h52},  // R2
    {OP_CHR, 8'h10, 1'b1, 1'b1, 4'hD, 8'h10},  // R1 break
    {OP_RDD, 8'h00, 1'b0, 1'b0, 4'h0, 8'h10},  // R2
    {OP_CHR, 8'h33, 1'b0, 1'b0, 4'h1, 8'h33},
    {OP_CHR, 8'h44, 1'b0, 1'b0, 4'h1, 8'h33},  // R3 hidden
    {OP_CHR, 8'h55, 1'b0, 1'b1, 4'h1, 8'h33},  // R3 last staged
    {OP_RDS, 8'h00, 1'b0, 1'b0, 4'h1, 8'h33},  // R3
    {OP_RDD, 8'h00, 1'b0, 1'b0, 4'hB, 8'h55},  // R4
    {OP_RDD, 8'h00, 1'b0, 1'b0, 4'hB, 8'h55},  // R5
    {OP_RDS, 8'h00, 1'b0, 1'b0, 4'hB, 8'h55},
    {OP_RDD, 8'h00, 1'b0, 1'b0, 4'h0, 8'h55}   // R6
  };

  logic clk = 1'b0, rst = 1'b1;
  logic char_done = 0, char_fe = 0, char_brk = 0, rd_data_stb = 0, rd_stat_stb = 0;
  logic ie_data = 0, ie_err = 0, ie_brg = 0, brg_reload = 0;
  logic [DW-1:0] char_data = '0;
  logic [DW-1:0] rx_data;
  logic [3:0] rx_stat;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  uart_rxq_status #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .char_done(char_done), .char_data(char_data),
    .char_fe(char_fe), .char_brk(char_brk), .rd_data_stb(rd_data_stb),
    .rd_stat_stb(rd_stat_stb), .ie_data(ie_data), .ie_err(ie_err),
    .ie_brg(ie_brg), .brg_reload(brg_reload), .rx_data(rx_data),
    .rx_stat(rx_stat), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input logic fe, input logic brk);
    @(negedge clk);
    char_done = 1; char_data = d; char_fe = fe; char_brk = brk;
    @(negedge clk);
    char_done = 0; char_fe = 0; char_brk = 0;
    settle();
  endtask

  task automatic rd_data();
    @(negedge clk); rd_data_stb = 1;
    @(negedge clk); rd_data_stb = 0;
    settle();
  endtask

  task automatic rd_stat();
    @(negedge clk); rd_stat_stb = 1;
    @(negedge clk); rd_stat_stb = 0;
    settle();
  endtask

  task automatic brg_pulse();
    @(negedge clk); brg_reload = 1;
    @(negedge clk); brg_reload = 0;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R10 stat", int'(rx_stat), 0);
    check("R10 data", int'(rx_data), 0);
    check("R10 irq", int'(irq), 0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][23:22])
        OP_CHR: send_char(VEC[i][21:14], VEC[i][13], VEC[i][12]);
        OP_RDD: rd_data();
        default: rd_stat();
      endcase
      check($sformatf("R1-6 vec%0d stat", i), int'(rx_stat), int'(VEC[i][11:8]));
      check($sformatf("R1-6 vec%0d data", i), int'(rx_data), int'(VEC[i][7:0]));
    end

    // R11: read and arrival in the same cycle
    send_char(8'h61, 0, 0);
    @(negedge clk);
    rd_data_stb = 1; char_done = 1; char_data = 8'h62;
    @(negedge clk);
    rd_data_stb = 0; char_done = 0;
    settle();
    check("R11 stat", int'(rx_stat), 1);
    check("R11 data", int'(rx_data), 8'h62);
    rd_data();

    // R7: data source and its own enable
    ie_data = 1;
    send_char(8'h11, 0, 0);
    check("R7 irq on data", int'(irq), 1);
    rd_data();
    check("R7 irq cleared", int'(irq), 0);
    ie_data = 0; ie_err = 1;
    send_char(8'h12, 0, 0);
    check("R7 data source disabled", int'(irq), 0);
    rd_data();

    // R8: error sources
    send_char(8'h13, 1, 0);
    check("R8 irq on framing", int'(irq), 1);
    rd_data();
    check("R8 irq cleared", int'(irq), 0);
    send_char(8'h20, 0, 0);
    send_char(8'h21, 0, 0);
    check("R8 hidden overrun no irq", int'(irq), 0);
    check("R3 stat hidden", int'(rx_stat), 1);
    rd_data();
    check("R8 irq on overrun", int'(irq), 1);
    check("R4 stat", int'(rx_stat), 3);
    check("R4 data", int'(rx_data), 8'h21);
    rd_stat();
    rd_data();
    check("R6 stat", int'(rx_stat), 0);
    check("R8 irq after clear", int'(irq), 0);

    // R9: reload-pulse source
    ie_err = 0;
    brg_pulse();
    check("R9 pulse disabled", int'(irq), 0);
    ie_brg = 1;
    settle();
    check("R9 no latent pulse", int'(irq), 0);
    brg_pulse();
    check("R9 irq on pulse", int'(irq), 1);
    rd_stat();
    check("R9 cleared by status read", int'(irq), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule